// File: doc/BRIEF.md
# Two-Wire Serial Shift Unit (Slave Side)

This block is the bit-level engine of a two-wire serial slave. It watches the clock and data lines of an open-drain bus and shifts incoming data bits into an 8-bit data register. It counts clock edges in a 4-bit counter and stretches the clock line at the moments when the local controller has to act. The unit never drives a line high. It only outputs drive-low enables, which the pad logic turns into open-drain pull-downs.

A controller on the register port handles everything above the bit level. It matches the address, decides whether to acknowledge, chooses the direction from the read/write bit, and reacts to stop conditions. The unit tells it when to act by raising flags and an interrupt: a start was seen, a byte or an acknowledge slot is complete, or a stop was seen. The controller uses the counter preload to choose between a full byte (counter at 0, sixteen edges) and a single acknowledge bit (counter at 14, two edges).

Top module: `tw_shift_unit`

## Requirements
- R1: A fall of the synchronized data line while the synchronized clock line is high, and was high on the previous sample, sets the start flag, which reads back as bit 7 of register address 1.
- R2: Once the start flag is set, the clock line is pulled low from the next falling clock edge until the controller writes status with bit 7 set. If bit 4 is set in that same write, the edge counter returns to 0.
- R3: On every rising clock edge the data register (address 0) shifts left by one and takes the sampled data line into bit 0, so the first bit received ends up in bit 7. After an acknowledge slot, bit 0 holds the acknowledge value that was seen on the bus.
- R4: The edge counter (address 2, bits 3:0) advances on every rising and every falling clock edge. When it wraps from 15 to 0 it sets the overflow flag (status bit 6) and pulls the clock line low until status is written with bit 6 set.
- R5: A counter preloaded with 14 overflows after exactly one more clock period, i.e. two edges, which is how a single acknowledge bit is framed.
- R6: The data line is pulled low only while the output enable (control register, address 3, bit 0) is 1 and the output bit is 0. The output bit takes data-register bit 7 on each falling clock edge and takes bit 7 of the written value on each data-register write, so it never changes while the clock is high unless the controller writes.
- R7: A rise of the data line while the clock line is high sets the stop flag (status bit 5). It also clears the start flag and releases every clock hold.
- R8: A start that arrives in the middle of a transfer (repeated start) sets the start flag again and drops any overflow hold. The start hold then engages on the next falling clock edge.
- R9: The interrupt output is high exactly when at least one flag is set whose enable is 1. The enables are control bit 1 for start, bit 2 for overflow and bit 3 for stop.
- R10: Flags clear only when the matching status bit is written with 1. A status write with the flag bits at 0 leaves every flag as it was.
- R11: After reset, all registers read 0, no flag and no interrupt is set, and neither line is pulled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sensed clock-line level (asynchronous) |
| sda_i | input | 1 | Sensed data-line level (asynchronous) |
| scl_drive_low_o | output | 1 | Pull the clock line low when 1 |
| sda_drive_low_o | output | 1 | Pull the data line low when 1 |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 2 | Register address: 0 data, 1 status, 2 counter, 3 control |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest states to reach are the ones where the controller and a stretched bus have to hand control back and forth: a clock hold released only by a flag clear, the acknowledge framed by a counter preload, and a repeated start arriving straight after an acknowledge was released. The bench reaches these by running a bus-master thread and a controller thread side by side. The master only raises the clock after it sees the line actually high, and the controller polls the status register, so every stretch resolves the way it would on a real bus. A behavioural reference model follows the same bus levels and register writes, and it is compared with all outputs and the read port on every cycle.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
// Package: shared register map and control-field layout of the two-wire
// shift unit. Assumes an 8-bit register port.
package tw_pkg;

    localparam logic [1:0] A_DATA   = 2'd0;
    localparam logic [1:0] A_STATUS = 2'd1;
    localparam logic [1:0] A_COUNT  = 2'd2;
    localparam logic [1:0] A_CTRL   = 2'd3;

    localparam int B_START  = 7;
    localparam int B_OVF    = 6;
    localparam int B_STOP   = 5;
    localparam int B_CNTRST = 4;

    typedef struct packed {
        logic ie_stop;
        logic ie_ovf;
        logic ie_start;
        logic oe;
    } tw_ctl_t;

endpackage

// File: rtl/tw_line_sync.sv
`timescale 1ns/1ps
// Module: tw_line_sync
// Brings both bus lines into the clock domain through a STAGES-deep
// synchronizer and derives clock edges plus start/stop conditions by
// comparing each synchronized level with the previous one.
// Assumes an idle bus is high, so every stage resets to 1.
module tw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic ev_rise,
    output logic ev_fall,
    output logic ev_start,
    output logic ev_stop
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // first stage captures the raw pin level
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        scl_pipe[0] <= 1'b1;
                        sda_pipe[0] <= 1'b1;
                    end else begin
                        scl_pipe[0] <= scl_in;
                        sda_pipe[0] <= sda_in;
                    end
                end
            end else begin : g_next
                // later stages pass the level along
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        scl_pipe[g] <= 1'b1;
                        sda_pipe[g] <= 1'b1;
                    end else begin
                        scl_pipe[g] <= scl_pipe[g-1];
                        sda_pipe[g] <= sda_pipe[g-1];
                    end
                end
            end
        end
    endgenerate

    assign scl_lvl = scl_pipe[STAGES-1];
    assign sda_lvl = sda_pipe[STAGES-1];

    // previous synchronized levels for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_lvl;
            sda_prev <= sda_lvl;
        end
    end

    // edge and bus-condition decode
    always_comb begin
        ev_rise  = scl_lvl & ~scl_prev;
        ev_fall  = ~scl_lvl & scl_prev;
        ev_start = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        ev_stop  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end

endmodule

// File: rtl/tw_shift_cnt.sv
`timescale 1ns/1ps
// Module: tw_shift_cnt
// Data shift register (MSB first, loaded on rising clock edges), output
// bit latch (loaded on falling edges), and the edge counter whose wrap
// marks the end of a byte or of an acknowledge slot.
// Assumes register writes take priority over bus edges in the same cycle.
module tw_shift_cnt #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_rise,
    input  logic              ev_fall,
    input  logic              sda_lvl,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_wdata,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              cnt_clr,
    output logic [DATA_W-1:0] data_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              out_bit,
    output logic              ovf_evt
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic edge_any;

    assign edge_any = ev_rise | ev_fall;
    assign ovf_evt  = edge_any & (cnt_q == CNT_TOP) & ~cnt_we & ~cnt_clr;

    // data register: CPU load or shift-in on rising clock
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (data_we) data_q <= data_wdata;
        else if (ev_rise) data_q <= {data_q[DATA_W-2:0], sda_lvl};
    end

    // output bit: follows the MSB at falling clock or on CPU load
    always_ff @(posedge clk) begin
        if (!rst_n)       out_bit <= 1'b1;
        else if (data_we) out_bit <= data_wdata[DATA_W-1];
        else if (ev_fall) out_bit <= data_q[DATA_W-1];
    end

    // edge counter: CPU load, clear with start acknowledge, or count
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (cnt_we)   cnt_q <= cnt_wdata;
        else if (cnt_clr)  cnt_q <= '0;
        else if (edge_any) cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/tw_flags.sv
`timescale 1ns/1ps
// Module: tw_flags
// Start, overflow and stop flags with write-one-to-clear, and the two
// clock-stretch holds (after start, after overflow).
// Assumes a flag being set wins over a clear in the same cycle.
module tw_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_fall,
    input  logic ev_start,
    input  logic ev_stop,
    input  logic ovf_evt,
    input  logic clr_start,
    input  logic clr_ovf,
    input  logic clr_stop,
    output logic start_f,
    output logic ovf_f,
    output logic stop_f,
    output logic scl_hold
);
    logic hold_start;
    logic hold_ovf;

    // start flag: set by start, dropped by stop or CPU clear
    always_ff @(posedge clk) begin
        if (!rst_n)                   start_f <= 1'b0;
        else if (ev_start)            start_f <= 1'b1;
        else if (ev_stop | clr_start) start_f <= 1'b0;
    end

    // overflow flag: set on counter wrap, CPU clear
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_f <= 1'b0;
        else if (ovf_evt) ovf_f <= 1'b1;
        else if (clr_ovf) ovf_f <= 1'b0;
    end

    // stop flag: set by stop, CPU clear
    always_ff @(posedge clk) begin
        if (!rst_n)        stop_f <= 1'b0;
        else if (ev_stop)  stop_f <= 1'b1;
        else if (clr_stop) stop_f <= 1'b0;
    end

    // start hold: engages on the falling edge after a start
    always_ff @(posedge clk) begin
        if (!rst_n)                                hold_start <= 1'b0;
        else if (ev_start | ev_stop | clr_start)   hold_start <= 1'b0;
        else if (ev_fall & start_f)                hold_start <= 1'b1;
    end

    // overflow hold: engages on wrap, released by clear or bus condition
    always_ff @(posedge clk) begin
        if (!rst_n)                  hold_ovf <= 1'b0;
        else if (ev_start | ev_stop) hold_ovf <= 1'b0;
        else if (ovf_evt)            hold_ovf <= 1'b1;
        else if (clr_ovf)            hold_ovf <= 1'b0;
    end

    assign scl_hold = hold_start | hold_ovf;

endmodule

// File: rtl/tw_shift_unit.sv
`timescale 1ns/1ps
// Module: tw_shift_unit (top)
// Slave-side two-wire shift unit: synchronizer/condition detector, shift
// and count datapath, flags and clock holds, and a four-entry register
// port with an interrupt. Outputs are drive-low enables for open-drain pads.
// Assumes DATA_W = 8 (status bit positions come from tw_pkg).
module tw_shift_unit #(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_drive_low_o,
    output logic              sda_drive_low_o,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    import tw_pkg::*;

    localparam int CTL_W = $bits(tw_ctl_t);

    logic              scl_lvl, sda_lvl;
    logic              ev_rise, ev_fall, ev_start, ev_stop;
    logic              wr_data, wr_stat, wr_cnt, wr_ctl;
    logic              clr_start, clr_ovf, clr_stop, cnt_clr;
    logic [DATA_W-1:0] data_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              out_bit, ovf_evt;
    logic              start_f, ovf_f, stop_f, scl_hold;
    tw_ctl_t           ctl_q;

    // register-port write decode
    always_comb begin
        wr_data   = reg_wr_i & (reg_addr_i == A_DATA);
        wr_stat   = reg_wr_i & (reg_addr_i == A_STATUS);
        wr_cnt    = reg_wr_i & (reg_addr_i == A_COUNT);
        wr_ctl    = reg_wr_i & (reg_addr_i == A_CTRL);
        clr_start = wr_stat & reg_wdata_i[B_START];
        clr_ovf   = wr_stat & reg_wdata_i[B_OVF];
        clr_stop  = wr_stat & reg_wdata_i[B_STOP];
        cnt_clr   = clr_start & reg_wdata_i[B_CNTRST];
    end

    tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_i),
        .sda_in   (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .ev_rise  (ev_rise),
        .ev_fall  (ev_fall),
        .ev_start (ev_start),
        .ev_stop  (ev_stop)
    );

    tw_shift_cnt #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_rise    (ev_rise),
        .ev_fall    (ev_fall),
        .sda_lvl    (sda_lvl),
        .data_we    (wr_data),
        .data_wdata (reg_wdata_i),
        .cnt_we     (wr_cnt),
        .cnt_wdata  (reg_wdata_i[CNT_W-1:0]),
        .cnt_clr    (cnt_clr),
        .data_q     (data_q),
        .cnt_q      (cnt_q),
        .out_bit    (out_bit),
        .ovf_evt    (ovf_evt)
    );

    tw_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_fall   (ev_fall),
        .ev_start  (ev_start),
        .ev_stop   (ev_stop),
        .ovf_evt   (ovf_evt),
        .clr_start (clr_start),
        .clr_ovf   (clr_ovf),
        .clr_stop  (clr_stop),
        .start_f   (start_f),
        .ovf_f     (ovf_f),
        .stop_f    (stop_f),
        .scl_hold  (scl_hold)
    );

    // control register: output enable and interrupt enables
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (wr_ctl) ctl_q <= reg_wdata_i[CTL_W-1:0];
    end

    // read mux
    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            A_DATA:   reg_rdata_o = data_q;
            A_STATUS: begin
                reg_rdata_o[B_START] = start_f;
                reg_rdata_o[B_OVF]   = ovf_f;
                reg_rdata_o[B_STOP]  = stop_f;
            end
            A_COUNT:  reg_rdata_o[CNT_W-1:0] = cnt_q;
            default:  reg_rdata_o[CTL_W-1:0] = ctl_q;
        endcase
    end

    assign scl_drive_low_o = scl_hold;
    assign sda_drive_low_o = ctl_q.oe & ~out_bit;
    assign irq_o = (start_f & ctl_q.ie_start) | (ovf_f & ctl_q.ie_ovf)
                 | (stop_f & ctl_q.ie_stop);

endmodule

// File: rtl/tw_shift_unit_chk.sv
`timescale 1ns/1ps
// Module: tw_shift_unit_chk
// Property checker bound into tw_shift_unit; observes the synchronized
// bus view, internal state and ports. Contains no design logic.
module tw_shift_unit_chk #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              sda_s,
    input logic              ev_rise,
    input logic              ev_start,
    input logic              ev_stop,
    input logic              wr_data,
    input logic              reg_wr,
    input logic [DATA_W-1:0] data_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              start_f,
    input logic              ovf_f,
    input logic              stop_f,
    input logic              scl_low,
    input logic              sda_low,
    input logic              irq
);

    assert_start_sets_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> start_f);

    assert_hold_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        scl_low |-> (start_f || ovf_f));

    assert_shift_lsb_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rise && !wr_data) |=> (data_q[0] == $past(sda_s)));

    assert_wrap_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_f) |-> (cnt_q == '0));

    assert_sda_quiet_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_low) && !$past(reg_wr)) |-> !$past(scl_s));

    assert_stop_effects_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> (stop_f && !start_f && !scl_low));

    assert_irq_has_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (start_f || ovf_f || stop_f));

endmodule

bind tw_shift_unit tw_shift_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_lvl),
    .sda_s    (sda_lvl),
    .ev_rise  (ev_rise),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .wr_data  (wr_data),
    .reg_wr   (reg_wr_i),
    .data_q   (data_q),
    .cnt_q    (cnt_q),
    .start_f  (start_f),
    .ovf_f    (ovf_f),
    .stop_f   (stop_f),
    .scl_low  (scl_drive_low_o),
    .sda_low  (sda_drive_low_o),
    .irq      (irq_o)
);

// File: tb/tw_shift_unit_tb.sv
`timescale 1ns/1ps
// Bench: bus-master thread plus controller thread, with a behavioural
// reference model compared on every clock.
module tw_shift_unit_tb;

    localparam int HB = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic       scl_dl, sda_dl, irq;
    logic [7:0] rdata;
    logic       scl_bus, sda_bus;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    assign scl_bus = m_scl & ~scl_dl;
    assign sda_bus = m_sda & ~sda_dl;

    tw_shift_unit u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_i           (scl_bus),
        .sda_i           (sda_bus),
        .scl_drive_low_o (scl_dl),
        .sda_drive_low_o (sda_dl),
        .reg_wr_i        (reg_wr),
        .reg_addr_i      (reg_addr),
        .reg_wdata_i     (reg_wdata),
        .reg_rdata_o     (rdata),
        .irq_o           (irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [2:0] ms, md;          // [0] newest sample ... [2] previous level
    logic [7:0] e_data;
    logic [3:0] e_cnt, e_ctl;
    logic       e_out, e_st, e_ov, e_sp, e_sh, e_oh;

    always @(posedge clk) begin : ref_model
        bit r, f, stc, spc, ovf, wd, ws, wc, wk, cst, cov, csp, ccl;
        if (!rst_n) begin
            ms = '1; md = '1; e_data = 0; e_cnt = 0; e_ctl = 0; e_out = 1;
            e_st = 0; e_ov = 0; e_sp = 0; e_sh = 0; e_oh = 0;
        end else begin
            r   = ms[1] & ~ms[2];
            f   = ~ms[1] & ms[2];
            stc = ms[1] & ms[2] & md[2] & ~md[1];
            spc = ms[1] & ms[2] & ~md[2] & md[1];
            wd  = reg_wr && reg_addr == 0;
            ws  = reg_wr && reg_addr == 1;
            wc  = reg_wr && reg_addr == 2;
            wk  = reg_wr && reg_addr == 3;
            cst = ws & reg_wdata[7];
            cov = ws & reg_wdata[6];
            csp = ws & reg_wdata[5];
            ccl = cst & reg_wdata[4];
            ovf = (r | f) && e_cnt == 4'hF && !wc && !ccl;
            if (stc | spc | cst) e_sh = 0; else if (f && e_st) e_sh = 1;
            if (stc | spc) e_oh = 0; else if (ovf) e_oh = 1; else if (cov) e_oh = 0;
            if (stc) e_st = 1; else if (spc | cst) e_st = 0;
            if (ovf) e_ov = 1; else if (cov) e_ov = 0;
            if (spc) e_sp = 1; else if (csp) e_sp = 0;
            if (wd) e_out = reg_wdata[7]; else if (f) e_out = e_data[7];
            if (wd) e_data = reg_wdata; else if (r) e_data = {e_data[6:0], md[1]};
            if (wc) e_cnt = reg_wdata[3:0]; else if (ccl) e_cnt = 0; else if (r | f) e_cnt = e_cnt + 1;
            if (wk) e_ctl = reg_wdata[3:0];
            ms = {ms[1:0], scl_bus};
            md = {md[1:0], sda_bus};
        end
    end

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0:    return e_data;
            2'd1:    return {e_st, e_ov, e_sp, 5'b0};
            2'd2:    return {4'b0, e_cnt};
            default: return {4'b0, e_ctl};
        endcase
    endfunction

    // per-cycle comparison against the model, away from the clock edge
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            check(scl_dl === (e_sh | e_oh), "R2 model scl hold", scl_dl, e_sh | e_oh);
            check(sda_dl === (e_ctl[0] & ~e_out), "R6 model sda drive", sda_dl, e_ctl[0] & ~e_out);
            check(irq === ((e_st & e_ctl[1]) | (e_ov & e_ctl[2]) | (e_sp & e_ctl[3])),
                  "R9 model irq", irq, (e_st & e_ctl[1]) | (e_ov & e_ctl[2]) | (e_sp & e_ctl[3]));
            check(rdata === exp_rd(reg_addr), "R10 model read port", rdata, exp_rd(reg_addr));
        end
    end

    // ---------------- controller tasks ----------------
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; #1; d = rdata;
    endtask

    task automatic wait_status(input logic [7:0] m);
        logic [7:0] s;
        do rd(1, s); while ((s & m) == 0);
    endtask

    task automatic ack_slave();
        logic [7:0] s;
        wr(0, 8'h00); wr(3, 8'h0F); wr(2, 8'd14); wr(1, 8'h40);
        wait_status(8'h40);
        rd(2, s); check(s == 0, "R5 ack framed by preload 14", s, 0);
        rd(0, s); check(s[0] == 0, "R3 own ack shifted in", s[0], 0);
        wr(3, 8'h0E); wr(2, 8'd0); wr(1, 8'h40);
    endtask

    // ---------------- bus master tasks ----------------
    task automatic half(); repeat (HB) @(negedge clk); endtask

    task automatic m_raise();
        m_scl = 1;
        do @(negedge clk); while (scl_bus !== 1'b1);
        half();
    endtask

    task automatic m_start_fall(); m_sda = 0; half(); m_scl = 0; half(); endtask

    task automatic m_bit_out(input logic b); m_sda = b; half(); m_raise(); m_scl = 0; half(); endtask

    task automatic m_bit_in(output logic b);
        m_sda = 1; half(); m_raise(); b = sda_bus; m_scl = 0; half();
    endtask

    task automatic m_send(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) m_bit_out(v[i]);
    endtask

    task automatic m_stop(); m_sda = 0; half(); m_raise(); m_sda = 1; half(); endtask

    task automatic m_rstart(); m_sda = 1; half(); m_raise(); m_sda = 0; half(); m_scl = 0; half(); endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        logic [7:0] s;
        logic b;
        logic [7:0] rb;
        repeat (5) @(negedge clk);
        rst_n = 1;

        // R11 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], s); check(s == 0, "R11 reset register", s, 0);
        end
        check(!scl_dl && !sda_dl && !irq, "R11 reset outputs", {scl_dl, sda_dl, irq}, 0);
        wr(3, 8'h0E);

        // write transfer: address 0xA4 then data 0x5B
        fork
            begin
                m_start_fall();
                m_send(8'hA4); m_bit_in(b); check(b == 0, "R6 slave ack on bus", b, 0);
                m_send(8'h5B); m_bit_in(b); check(b == 0, "R6 slave ack on bus", b, 0);
                m_stop();
            end
            begin
                wait_status(8'h80);
                rd(1, s); check(s == 8'h80, "R1 start flag", s, 8'h80);
                check(irq == 1, "R9 start irq", irq, 1);
                repeat (40) @(negedge clk);
                check(scl_dl == 1, "R2 hold after start", scl_dl, 1);
                wr(1, 8'h90);
                rd(2, s); check(s == 0, "R2 counter reset with start clear", s, 0);
                wait_status(8'h40);
                rd(0, s); check(s == 8'hA4, "R3 address byte msb first", s, 8'hA4);
                rd(2, s); check(s == 0, "R4 counter wrapped", s, 0);
                check(scl_dl == 1, "R4 hold on overflow", scl_dl, 1);
                ack_slave();
                wait_status(8'h40);
                rd(0, s); check(s == 8'h5B, "R3 data byte", s, 8'h5B);
                ack_slave();
                wait_status(8'h20);
                rd(1, s); check(s == 8'h20, "R7 stop flag only", s, 8'h20);
                check(scl_dl == 0, "R7 no hold after stop", scl_dl, 0);
                wr(1, 8'h20);
            end
        join

        // read transfer: address 0xA5, slave sends 0x3C, master NACKs
        fork
            begin
                m_start_fall();
                m_send(8'hA5); m_bit_in(b); check(b == 0, "R6 address ack", b, 0);
                rb = 0;
                for (int i = 0; i < 8; i++) begin
                    m_bit_in(b); rb = {rb[6:0], b};
                end
                check(rb == 8'h3C, "R6 slave read data", rb, 8'h3C);
                m_bit_out(1'b1);
                m_stop();
            end
            begin
                wait_status(8'h80); wr(1, 8'h90);
                wait_status(8'h40);
                rd(0, s); check(s == 8'hA5, "R3 read address with dir bit", s, 8'hA5);
                wr(0, 8'h00); wr(3, 8'h0F); wr(2, 8'd14); wr(1, 8'h40);
                wait_status(8'h40);
                wr(0, 8'h3C); wr(2, 8'd0); wr(1, 8'h40);
                wait_status(8'h40);
                rd(0, s); check(s == 8'h3C, "R3 transmitted byte shifted back", s, 8'h3C);
                wr(3, 8'h0E); wr(2, 8'd14); wr(1, 8'h40);
                wait_status(8'h40);
                rd(0, s); check(s[0] == 1, "R3 master nack seen", s[0], 1);
                wr(2, 8'd0); wr(1, 8'h40);
                wait_status(8'h20); wr(1, 8'h20);
            end
        join

        // start immediately followed by stop, then free clocking
        m_sda = 0; half(); m_sda = 1; half();
        rd(1, s); check(s == 8'h20, "R7 stop clears start flag", s, 8'h20);
        m_scl = 0; half();
        check(scl_dl == 0, "R7 no start hold after stop", scl_dl, 0);
        m_raise();
        wr(3, 8'h00);
        check(irq == 0, "R9 irq masked", irq, 0);
        wr(1, 8'h00);
        rd(1, s); check(s == 8'h20, "R10 zero write keeps flag", s, 8'h20);
        wr(1, 8'h20);
        rd(1, s); check(s == 8'h00, "R10 write one clears", s, 0);
        wr(3, 8'h0E);

        // repeated start
        fork
            begin
                m_start_fall();
                m_send(8'hC2); m_bit_in(b);
                m_rstart();
                m_send(8'h81); m_bit_in(b);
                m_stop();
            end
            begin
                wait_status(8'h80); wr(1, 8'h90);
                wait_status(8'h40);
                rd(0, s); check(s == 8'hC2, "R3 first byte", s, 8'hC2);
                ack_slave();
                wait_status(8'h80);
                rd(1, s); check(s[7] == 1, "R8 repeated start flag", s[7], 1);
                repeat (40) @(negedge clk);
                check(scl_dl == 1, "R8 start hold re-engages", scl_dl, 1);
                wr(1, 8'h90);
                wait_status(8'h40);
                rd(0, s); check(s == 8'h81, "R8 byte after repeated start", s, 8'h81);
                ack_slave();
                wait_status(8'h20); wr(1, 8'h20);
            end
        join

        repeat (10) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule